// File: doc/BRIEF.md
# Two-Channel Programmable Interval Timer

This block holds a set of independent 16-bit down-counting timers, two by default, all clocked by one shared functional clock. Each channel scales that clock by its own power-of-two prescaler, counts down from a programmed load value, and flags terminal count in a status bit. A flagged channel can drive its own interrupt line. Each channel can run periodically with automatic reload, or stop itself after one interval.

Software reaches every channel through a flat register port with 16-bit data. Each channel has four registers: control, interrupt status, load and live count. A typical use gives one channel to periodic or one-shot event generation and leaves another free-running as a time base, which software reads back from the count register.

Top module: `dual_interval_timer`

## Requirements
- R1: After a synchronous reset every register of every channel reads zero, every interrupt line is low and the read data is zero.
- R2: Channel n (from 0) decodes at byte address 0x80*(n+1) plus 0x0 for control, 0x4 for status, 0x8 for load and 0xC for count. Read data is registered and shows the addressed register one clock after the address. Any other address reads zero and ignores writes. The control register holds interrupt enable in bit 8, run enable in bit 5, one-shot select in bit 4 and the prescaler code in bits [3:0]. Its other bits read zero.
- R3: A running channel with prescaler code k takes one count step every 2^k functional clocks. Codes 9 to 15 act as code 8 (divide by 256). The first step after run enable goes from 0 to 1 falls exactly 2^k clocks after the enabling write.
- R4: Each count step lowers the count by one. A step whose result is zero sets status bit 0.
- R5: With one-shot select clear, a step taken while the count is zero reloads the load value. The period is therefore load+1 steps.
- R6: With one-shot select set, the step that reaches zero also clears run enable, and the count stays at zero.
- R7: A write to the load register while run enable is clear also copies the value into the count. While running, it changes only the load register.
- R8: While run enable is clear, the count holds its value.
- R9: Writing status with bit 0 set clears the flag. Writing bit 0 as zero has no effect. A terminal count in the same clock wins over the clear.
- R10: A channel's interrupt line is high one clock after a clock in which both its status flag and its interrupt enable were set.
- R11: A register access to one channel leaves every other channel's registers and interrupt line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the previous clock's address |
| irq | output | 2 | Per-channel registered interrupt lines |

## Verification
Read data is due one clock after the address, and an interrupt line follows its flag one clock later. A write takes effect at the edge that captures it. The first count step comes 2^k clocks after that edge, so a one-shot with load L raises its interrupt L*2^k+1 clocks after the enabling write. The reference model advances at each rising edge from the inputs held stable since the previous falling edge. The model's read data and interrupt lines are compared at every falling edge. The directed checks count falling edges from the end of a write to the exact clock at which each result is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register select within a channel block (byte address bits [3:2])
  typedef enum logic [1:0] {
    RS_CTRL  = 2'd0,
    RS_STAT  = 2'd1,
    RS_LOAD  = 2'd2,
    RS_COUNT = 2'd3
  } reg_sel_e;

  // Control field positions
  localparam int CB_IRQ_EN  = 8;
  localparam int CB_RUN     = 5;
  localparam int CB_ONESHOT = 4;
  localparam int CB_CODE_LO = 0;
  localparam int CODE_W     = 4;

  // Byte span of one channel block (log2)
  localparam int BLK_SHIFT  = 7;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int MAX_SHIFT = 8,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PRE_W = MAX_SHIFT;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;

  // limit = 2^min(code,MAX_SHIFT) - 1
  always_comb begin
    for (int b = 0; b < PRE_W; b++) begin
      limit[b] = (32'(code) > b);
    end
  end

  assign tick = run && (pre_cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
    end else if (!run || tick) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R3: divider restarts from zero when the channel starts
  p_pre_restart_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (pre_cnt == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] stat_word,
  output logic [DATA_W-1:0] load_word,
  output logic [DATA_W-1:0] count_word,
  output logic              irq
);
  logic              irq_en_q;
  logic              run_q;
  logic              oneshot_q;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] count_q;
  logic              flag_q;
  logic              irq_q;
  logic              tick;
  logic [DATA_W-1:0] next_cnt;
  logic              hit_zero;

  tmr_prescale #(
    .MAX_SHIFT (MAX_SHIFT),
    .CODE_W    (CODE_W)
  ) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run_q),
    .code (code_q),
    .tick (tick)
  );

  assign next_cnt = (count_q == '0) ? load_q : (count_q - 1'b1);
  assign hit_zero = tick && (next_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q  <= 1'b0;
      run_q     <= 1'b0;
      oneshot_q <= 1'b0;
      code_q    <= '0;
      load_q    <= '0;
      count_q   <= '0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (tick) begin
        count_q <= next_cnt;
      end
      if (hit_zero && oneshot_q) begin
        run_q <= 1'b0;
      end
      if (wr_load) begin
        load_q <= wdata;
        if (!run_q) begin
          count_q <= wdata;
        end
      end
      if (wr_ctrl) begin
        irq_en_q  <= wdata[CB_IRQ_EN];
        run_q     <= wdata[CB_RUN];
        oneshot_q <= wdata[CB_ONESHOT];
        code_q    <= wdata[CB_CODE_LO +: CODE_W];
      end
      if (wr_stat && wdata[0]) begin
        flag_q <= 1'b0;
      end
      if (hit_zero) begin
        flag_q <= 1'b1;
      end
      irq_q <= flag_q && irq_en_q;
    end
  end

  always_comb begin
    ctrl_word                       = '0;
    ctrl_word[CB_IRQ_EN]            = irq_en_q;
    ctrl_word[CB_RUN]               = run_q;
    ctrl_word[CB_ONESHOT]           = oneshot_q;
    ctrl_word[CB_CODE_LO +: CODE_W] = code_q;
    stat_word                       = '0;
    stat_word[0]                    = flag_q;
  end

  assign load_word  = load_q;
  assign count_word = count_q;
  assign irq        = irq_q;

  // R8: a stopped channel keeps its count unless load is written
  p_count_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_load) |=> (count_q == $past(count_q)));

  // R6: a self-stop leaves the count at zero with the flag raised
  p_oneshot_end_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(run_q) && !$past(wr_ctrl)) |-> (count_q == '0 && flag_q));

  // R9: write-one clears the flag when no terminal count coincides
  p_flag_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata[0] && !hit_zero) |=> !flag_q);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import tmr_pkg::*;
#(
  parameter int N_CH      = 2,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int MAX_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_CH-1:0]   irq
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic [BLK_W-1:0]  blk;
  logic              off_ok;
  logic              addr_ok;
  reg_sel_e          rsel;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  logic [DATA_W-1:0] ctrl_w  [N_CH];
  logic [DATA_W-1:0] stat_w  [N_CH];
  logic [DATA_W-1:0] load_w  [N_CH];
  logic [DATA_W-1:0] count_w [N_CH];

  assign blk     = bus_addr[ADDR_W-1:BLK_SHIFT];
  assign off_ok  = (bus_addr[BLK_SHIFT-1:4] == '0) && (bus_addr[1:0] == 2'b00);
  assign rsel    = reg_sel_e'(bus_addr[3:2]);
  assign addr_ok = off_ok && (blk != '0) && (blk <= BLK_W'(N_CH));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic sel;
    assign sel = addr_ok && (blk == BLK_W'(i + 1));

    tmr_channel #(
      .DATA_W    (DATA_W),
      .MAX_SHIFT (MAX_SHIFT)
    ) u_ch (
      .clk        (clk),
      .rst        (rst),
      .wr_ctrl    (bus_wr && sel && (rsel == RS_CTRL)),
      .wr_stat    (bus_wr && sel && (rsel == RS_STAT)),
      .wr_load    (bus_wr && sel && (rsel == RS_LOAD)),
      .wdata      (bus_wdata),
      .ctrl_word  (ctrl_w[i]),
      .stat_word  (stat_w[i]),
      .load_word  (load_w[i]),
      .count_word (count_w[i]),
      .irq        (irq[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (addr_ok && (blk == BLK_W'(i + 1))) begin
        unique case (rsel)
          RS_CTRL:  rd_mux = ctrl_w[i];
          RS_STAT:  rd_mux = stat_w[i];
          RS_LOAD:  rd_mux = load_w[i];
          RS_COUNT: rd_mux = count_w[i];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;

  // R2: unmapped addresses read back as zero one clock later
  p_rdata_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
    !addr_ok |=> (bus_rdata == '0));
endmodule

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
  localparam int CLK_P = 10;
  localparam int NCH   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_interval_timer dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit      m_ie [NCH], m_run [NCH], m_os [NCH], m_flag [NCH], m_irq [NCH];
  int      m_code [NCH], m_load [NCH], m_cnt [NCH], m_pre [NCH];
  int      m_rdata;
  string   m_tag;

  function automatic void dec(input int a, output bit ok, output int ch, output int rs);
    int b;
    b  = a >> 7;
    rs = (a >> 2) & 3;
    ch = b - 1;
    ok = (b >= 1) && (b <= NCH) && ((a & 'h73) == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_ie[c] = 0; m_run[c] = 0; m_os[c] = 0; m_flag[c] = 0; m_irq[c] = 0;
        m_code[c] = 0; m_load[c] = 0; m_cnt[c] = 0; m_pre[c] = 0;
      end
      m_rdata = 0;
      m_tag = "R1";
    end else begin
      bit ok; int ch; int rs;
      dec(int'(bus_addr), ok, ch, rs);
      // read of the state before this edge
      m_rdata = 0;
      m_tag = "R2";
      if (ok) begin
        case (rs)
          0: m_rdata = (int'(m_ie[ch]) << 8) | (int'(m_run[ch]) << 5) |
                       (int'(m_os[ch]) << 4) | m_code[ch];
          1: begin m_rdata = int'(m_flag[ch]); m_tag = "R9"; end
          2: begin m_rdata = m_load[ch]; m_tag = "R7"; end
          default: begin m_rdata = m_cnt[ch]; m_tag = "R3,R4,R5,R6,R8,R11"; end
        endcase
      end
      for (int c = 0; c < NCH; c++) begin
        int  div, nxt;
        bit  tk, hz, run_n, flag_n;
        int  cnt_n, pre_n;
        div    = 1 << ((m_code[c] > 8) ? 8 : m_code[c]);
        tk     = m_run[c] && (m_pre[c] >= div - 1);
        pre_n  = (!m_run[c] || tk) ? 0 : m_pre[c] + 1;
        cnt_n  = m_cnt[c];
        run_n  = m_run[c];
        flag_n = m_flag[c];
        hz     = 0;
        if (tk) begin
          nxt = (m_cnt[c] == 0) ? m_load[c] : m_cnt[c] - 1;
          cnt_n = nxt;
          hz = (nxt == 0);
          if (hz && m_os[c]) run_n = 0;
        end
        m_irq[c] = m_flag[c] && m_ie[c];
        if (bus_wr && ok && ch == c) begin
          case (rs)
            0: begin
              m_ie[c] = bus_wdata[8]; run_n = bus_wdata[5];
              m_os[c] = bus_wdata[4]; m_code[c] = int'(bus_wdata[3:0]);
            end
            1: if (bus_wdata[0]) flag_n = 0;
            2: begin
              m_load[c] = int'(bus_wdata);
              if (!m_run[c]) cnt_n = int'(bus_wdata);
            end
            default: ;
          endcase
        end
        if (hz) flag_n = 1;
        m_cnt[c] = cnt_n; m_pre[c] = pre_n; m_run[c] = run_n; m_flag[c] = flag_n;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(bus_rdata) == m_rdata, m_tag, int'(bus_rdata), m_rdata);
      for (int c = 0; c < NCH; c++)
        chk(irq[c] == m_irq[c], "R10", int'(irq[c]), int'(m_irq[c]));
    end
  end

  // ---------------- stimulus ----------------
  int rot = 0;

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 10'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      int r;
      @(negedge clk);
      r = rot % 9;
      bus_addr = (r < 8) ? 10'('h80 * (1 + r / 4) + 4 * (r % 4)) : 10'h3F0;
      rot++;
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); bus_addr = 10'(a);
    @(negedge clk); v = int'(bus_rdata);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int v0, v1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(bus_rdata == 16'h0 && irq == 2'b00, "R1", int'({irq, bus_rdata}), 0);
    idle(12);

    // R6 / R10: one-shot, load 3, code 0 -> irq 4 clocks after enabling write
    wr('h088, 3);
    wr('h080, 'h0130);
    repeat (3) @(negedge clk);
    chk(irq[0] == 1'b0, "R6", int'(irq[0]), 0);
    @(negedge clk);
    chk(irq[0] == 1'b1, "R6", int'(irq[0]), 1);
    rd('h080, v0);
    chk(v0 == 'h0110, "R6", v0, 'h0110);
    wr('h084, 0);          // R9: zero write leaves flag
    idle(3);
    wr('h084, 1);          // R9: clear
    idle(3);
    chk(irq[0] == 1'b0, "R9", int'(irq[0]), 0);

    // R3: one-shot, load 1, code 3 -> irq 9 clocks after enabling write
    wr('h088, 1);
    wr('h080, 'h0133);
    repeat (8) @(negedge clk);
    chk(irq[0] == 1'b0, "R3", int'(irq[0]), 0);
    @(negedge clk);
    chk(irq[0] == 1'b1, "R3", int'(irq[0]), 1);
    wr('h084, 1);

    // R5: auto-reload on channel 1, divide by 4
    wr('h108, 5);
    wr('h100, 'h0122);
    idle(200);
    wr('h104, 1);
    idle(60);

    // R7: load write while running changes only load
    wr('h108, 9);
    idle(120);

    // R8: stop channel 1, count holds
    wr('h100, 'h0102);
    rd('h10C, v0);
    idle(40);
    rd('h10C, v1);
    chk(v0 == v1, "R8", v1, v0);

    // R11: channel 1 writes leave channel 0 count alone
    rd('h08C, v0);
    wr('h108, 'h1234);
    wr('h104, 1);
    rd('h08C, v1);
    chk(v0 == v1, "R11", v1, v0);

    // R2: unmapped writes ignored, reads zero
    wr('h000, 'hFFFF);
    wr('h090, 'hFFFF);
    wr('h3F0, 'hFFFF);
    rd('h090, v0);
    chk(v0 == 0, "R2", v0, 0);

    // R3: oversize code acts as 256, auto-reload on channel 0
    wr('h088, 2);
    wr('h080, 'h012C);
    idle(1700);
    wr('h084, 1);
    wr('h080, 'h0000);

    // R3: sweep all codes on channel 1, one-shot load 1
    for (int k = 0; k < 16; k++) begin
      wr('h104, 1);
      wr('h108, 1);
      wr('h100, 'h0130 | k);
      idle((k > 8) ? 260 : (1 << k) + 4);
    end

    // R9: clear coinciding with terminal count, code 0 auto-reload load 0
    wr('h108, 0);
    wr('h100, 'h0120);
    for (int i = 0; i < 6; i++) wr('h104, 1);
    idle(10);

    done = 1;
    summary();
    $finish;
  end
endmodule